// File: doc/BRIEF.md
# Serial Control Register Port

This block receives configuration words for an audio playback chip over a three-wire, write-only serial link made of a shift clock, a data line and a latch line. Each word is 16 bits long and arrives most significant bit first. The two lowest bits of the word choose one of four configuration registers: left-channel volume, right-channel volume, converter control and clock-generator control. The rest of the chip reads the decoded fields on parallel outputs.

All three serial pins are brought into the system clock domain through synchroniser stages. Edges of the shift clock are then detected there, so the serial clock may be gated or may run all the time. A word takes effect on the rising edge of the latch line, but only when exactly sixteen shift-clock rising edges arrived while the latch was low. Two field codes are reserved: interpolation code 11 and sample-rate code 01. If a written word carries one of them, that field keeps its previous value. The other fields in the same word still update.

Top module: `ctl_spi_port`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first write, both volume outputs read 14'h3FFF and every converter and clock-generator field reads 0.
- R2: While `ser_lat` is low, each rising edge of `ser_clk` shifts in one bit from `ser_dat`, most significant bit first. On the rising edge of `ser_lat`, the last 16 bits shifted in form the word.
- R3: A latch rise that follows any number of shift-clock rising edges other than 16 (fewer or more) changes no output.
- R4: Word bits 1:0 select the register: 00 is left volume, 10 is right volume, 01 is converter control and 11 is clock-generator control. A write changes only the selected register.
- R5: In a volume write, bits 15:2 give the 14-bit unsigned volume for the selected channel.
- R6: In a converter-control write, the fields are placed as follows. Bits 11:10 give the interpolation code: 00 = 8x, 01 = 4x, 10 = 2x. Bits 9:8 give the word width: 00 = 24, 01 = 20, 1x = 16. Bit 7 inverts the output phase. Bit 6 is soft mute. Bits 5:4 give the serial format: 00 = I2S, 01 = right-justified, 10 = DSP, 11 = left-justified. Bits 3:2 give de-emphasis: 00 = none, 01 = 44.1 kHz, 10 = 32 kHz, 11 = 48 kHz. Bits 15:12 are ignored.
- R7: A converter-control write with interpolation code 11 leaves `dac_interp` at its previous value and still updates every other converter field.
- R8: In a clock-generator write, the fields are placed as follows. Bit 11 powers down the second PLL and bit 10 powers down the first PLL. Bit 9 powers down the crystal oscillator and bit 8 halves the reference. Bits 7:6 give the sample rate: 00 = 48 kHz, 10 = 32 kHz, 11 = 44.1 kHz. Bit 5 selects the 384x audio clock and bit 4 doubles the audio clock. Bit 3 selects the rate-locked processor clock. Bit 2 makes the master clock pin an input. Bits 15:12 are ignored.
- R9: A clock-generator write with rate code 01 leaves `pll_rate` at its previous value and still updates every other clock-generator field.
- R10: Shift-clock edges that arrive while `ser_lat` is high shift nothing and do not count toward the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least several times faster than `ser_clk` |
| rst_n | input | 1 | Active-low reset; restores every default |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_dat | input | 1 | Serial data, sampled on rising `ser_clk` |
| ser_lat | input | 1 | Latch line; low while a word is shifted, a rising edge commits the word |
| vol_left | output | 14 | Left-channel volume |
| vol_right | output | 14 | Right-channel volume |
| dac_interp | output | 2 | Interpolation factor code |
| dac_width | output | 2 | Serial word width code |
| dac_phase_inv | output | 1 | Output phase inversion |
| dac_soft_mute | output | 1 | Soft mute |
| dac_format | output | 2 | Serial data format code |
| dac_deemph | output | 2 | De-emphasis selection |
| pll2_off | output | 1 | Power down of the second PLL |
| pll1_off | output | 1 | Power down of the first PLL |
| xtal_off | output | 1 | Power down of the crystal oscillator |
| ref_half | output | 1 | Halves the reference for all generated clocks |
| pll_rate | output | 2 | Sample-rate family code |
| aclk_x384 | output | 1 | Audio clock at 384x instead of 256x |
| aclk_dbl | output | 1 | Audio clock doubled |
| dspclk_rate | output | 1 | Processor clock locked to the sample rate instead of fixed |
| mclk_is_in | output | 1 | Master clock pin acts as input |

## Verification
Some properties are checked on every cycle. The bit counter never passes its saturation value, and it is empty whenever a word is handed to the register bank. No shifting happens while the latch is high. At most one register is selected for writing at a time. The configuration holds still on any cycle without a write. The two reserved codes never appear on `dac_interp` or `pll_rate`. Other behaviours depend on the whole serial sequence, so only the bench scenarios can show them. These are correct field placement for each register, MSB-first ordering, the discarding of 15-bit and 17-bit frames, the ignoring of clock edges while the latch is high, and the restore of defaults when reset is applied in the middle of operation.

// File: rtl/cp_pkg.sv
package cp_pkg;

   typedef enum logic [1:0] {
      SEL_VOL_L = 2'b00,
      SEL_DAC   = 2'b01,
      SEL_VOL_R = 2'b10,
      SEL_PLL   = 2'b11
   } cp_sel_e;

   // Field order from MSB matches word bits 11:2
   typedef struct packed {
      logic [1:0] interp;
      logic [1:0] width;
      logic       phase_inv;
      logic       soft_mute;
      logic [1:0] format;
      logic [1:0] deemph;
   } dac_cfg_t;

   typedef struct packed {
      logic       pll2_off;
      logic       pll1_off;
      logic       xtal_off;
      logic       ref_half;
      logic [1:0] rate;
      logic       aclk_x384;
      logic       aclk_dbl;
      logic       dspclk_rate;
      logic       mclk_is_in;
   } pll_cfg_t;

   localparam int          CFG_W       = $bits(dac_cfg_t);
   localparam logic [1:0]  INTERP_RSVD = 2'b11;
   localparam logic [1:0]  RATE_RSVD   = 2'b01;

endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cp_shift_rx.sv
module cp_shift_rx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              slat_s,
   output logic [WORD_W-1:0] word_o,
   output logic              wr_vld_o
);
   localparam int              CNT_W   = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;
   logic              sclk_q;
   logic              slat_q;
   logic              sclk_rise;
   logic              slat_rise;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign slat_rise = slat_s & ~slat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         bit_cnt  <= '0;
         sclk_q   <= 1'b0;
         slat_q   <= 1'b1;
         word_o   <= '0;
         wr_vld_o <= 1'b0;
      end else begin
         sclk_q   <= sclk_s;
         slat_q   <= slat_s;
         wr_vld_o <= 1'b0;
         if (slat_s) begin
            bit_cnt <= '0;
            if (slat_rise && bit_cnt == CNT_FULL) begin
               word_o   <= shreg;
               wr_vld_o <= 1'b1;
            end
         end else if (sclk_rise) begin
            shreg <= {shreg[WORD_W-2:0], sdat_s};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   // R3: counter saturates, never wraps back to a valid count
   a_r3_cnt_bounded : assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_SAT);

   // R2: a handed-over word always leaves an empty counter behind
   a_r2_cnt_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld_o |-> bit_cnt == '0);

   // R10: no shifting while the latch stays high
   a_r10_no_shift : assert property (@(posedge clk) disable iff (!rst_n)
      (slat_s && slat_q) |=> $stable(shreg));
endmodule

// File: rtl/cp_reg_bank.sv
module cp_reg_bank
   import cp_pkg::*;
#(
   parameter int              WORD_W  = 16,
   parameter int              VOL_W   = 14,
   parameter int              N_CHAN  = 2,
   parameter logic [VOL_W-1:0] VOL_DEF = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_vld,
   input  logic [WORD_W-1:0] word,
   output logic [VOL_W-1:0]  vol [N_CHAN],
   output dac_cfg_t          dac_q,
   output pll_cfg_t          pll_q
);
   localparam int SEL_W = 2;

   cp_sel_e     sel;
   logic [3:0]  wr_sel;
   dac_cfg_t    dac_new;
   pll_cfg_t    pll_new;
   dac_cfg_t    dac_nxt;
   pll_cfg_t    pll_nxt;

   assign sel     = cp_sel_e'(word[SEL_W-1:0]);
   assign dac_new = dac_cfg_t'(word[SEL_W+CFG_W-1:SEL_W]);
   assign pll_new = pll_cfg_t'(word[SEL_W+CFG_W-1:SEL_W]);

   always_comb begin
      wr_sel = '0;
      if (wr_vld) wr_sel[sel] = 1'b1;
   end

   always_comb begin
      dac_nxt = dac_new;
      if (dac_new.interp == INTERP_RSVD) dac_nxt.interp = dac_q.interp;
      pll_nxt = pll_new;
      if (pll_new.rate == RATE_RSVD) pll_nxt.rate = pll_q.rate;
   end

   // Volume channel c answers select code {c, 0}
   for (genvar c = 0; c < N_CHAN; c++) begin : g_vol
      localparam int SEL_IDX = c * 2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              vol[c] <= VOL_DEF;
         else if (wr_sel[SEL_IDX]) vol[c] <= word[WORD_W-1:WORD_W-VOL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_q <= '0;
         pll_q <= '0;
      end else begin
         if (wr_sel[SEL_DAC]) dac_q <= dac_nxt;
         if (wr_sel[SEL_PLL]) pll_q <= pll_nxt;
      end
   end

   // R4: at most one register selected for a write
   a_r4_one_target : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

   // R3: no write, no change
   a_r3_idle_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vld |=> ($stable(dac_q) && $stable(pll_q) && $stable(vol[0]) && $stable(vol[N_CHAN-1])));

   // R7: reserved interpolation code never reaches the output
   a_r7_interp_legal : assert property (@(posedge clk) disable iff (!rst_n)
      dac_q.interp != INTERP_RSVD);

   // R9: reserved rate code never reaches the output
   a_r9_rate_legal : assert property (@(posedge clk) disable iff (!rst_n)
      pll_q.rate != RATE_RSVD);
endmodule

// File: rtl/ctl_spi_port.sv
module ctl_spi_port
   import cp_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int VOL_W       = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_dat,
   input  logic             ser_lat,
   output logic [VOL_W-1:0] vol_left,
   output logic [VOL_W-1:0] vol_right,
   output logic [1:0]       dac_interp,
   output logic [1:0]       dac_width,
   output logic             dac_phase_inv,
   output logic             dac_soft_mute,
   output logic [1:0]       dac_format,
   output logic [1:0]       dac_deemph,
   output logic             pll2_off,
   output logic             pll1_off,
   output logic             xtal_off,
   output logic             ref_half,
   output logic [1:0]       pll_rate,
   output logic             aclk_x384,
   output logic             aclk_dbl,
   output logic             dspclk_rate,
   output logic             mclk_is_in
);
   localparam int N_PIN  = 3;
   localparam int N_CHAN = 2;

   if (WORD_W != VOL_W + 2) begin : g_bad_vol
      $error("ctl_spi_port: VOL_W must fill the word above the select bits");
   end
   if (WORD_W < CFG_W + 2) begin : g_bad_word
      $error("ctl_spi_port: WORD_W too small for the config fields");
   end

   logic [N_PIN-1:0] pin_raw;
   logic [N_PIN-1:0] pin_s;

   assign pin_raw = {ser_lat, ser_dat, ser_clk};

   for (genvar i = 0; i < N_PIN; i++) begin : g_sync
      cp_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pin_raw[i]),
         .q     (pin_s[i])
      );
   end

   logic [WORD_W-1:0] word;
   logic              wr_vld;

   cp_shift_rx #(.WORD_W(WORD_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (pin_s[0]),
      .sdat_s   (pin_s[1]),
      .slat_s   (pin_s[2]),
      .word_o   (word),
      .wr_vld_o (wr_vld)
   );

   logic [VOL_W-1:0] vol [N_CHAN];
   dac_cfg_t         dac_q;
   pll_cfg_t         pll_q;

   cp_reg_bank #(
      .WORD_W (WORD_W),
      .VOL_W  (VOL_W),
      .N_CHAN (N_CHAN)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_vld (wr_vld),
      .word   (word),
      .vol    (vol),
      .dac_q  (dac_q),
      .pll_q  (pll_q)
   );

   assign vol_left      = vol[0];
   assign vol_right     = vol[1];
   assign dac_interp    = dac_q.interp;
   assign dac_width     = dac_q.width;
   assign dac_phase_inv = dac_q.phase_inv;
   assign dac_soft_mute = dac_q.soft_mute;
   assign dac_format    = dac_q.format;
   assign dac_deemph    = dac_q.deemph;
   assign pll2_off      = pll_q.pll2_off;
   assign pll1_off      = pll_q.pll1_off;
   assign xtal_off      = pll_q.xtal_off;
   assign ref_half      = pll_q.ref_half;
   assign pll_rate      = pll_q.rate;
   assign aclk_x384     = pll_q.aclk_x384;
   assign aclk_dbl      = pll_q.aclk_dbl;
   assign dspclk_rate   = pll_q.dspclk_rate;
   assign mclk_is_in    = pll_q.mclk_is_in;
endmodule

// File: tb/tb_ctl_spi_port.sv
module tb_ctl_spi_port;
   localparam int HALF  = 13;
   localparam int N_VEC = 8;
   localparam logic [15:0] VEC [N_VEC] = '{
      16'h1234, 16'hABCE, 16'h06B5, 16'h0FFF,
      16'h0C19, 16'h0A47, 16'hFFFC, 16'h0002
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b1;
   logic [13:0] vol_left, vol_right;
   logic [1:0]  dac_interp, dac_width, dac_format, dac_deemph, pll_rate;
   logic        dac_phase_inv, dac_soft_mute, pll2_off, pll1_off, xtal_off;
   logic        ref_half, aclk_x384, aclk_dbl, dspclk_rate, mclk_is_in;

   always #2.5 clk = ~clk;

   ctl_spi_port dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
      .vol_left(vol_left), .vol_right(vol_right), .dac_interp(dac_interp),
      .dac_width(dac_width), .dac_phase_inv(dac_phase_inv), .dac_soft_mute(dac_soft_mute),
      .dac_format(dac_format), .dac_deemph(dac_deemph), .pll2_off(pll2_off),
      .pll1_off(pll1_off), .xtal_off(xtal_off), .ref_half(ref_half), .pll_rate(pll_rate),
      .aclk_x384(aclk_x384), .aclk_dbl(aclk_dbl), .dspclk_rate(dspclk_rate),
      .mclk_is_in(mclk_is_in)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // Bench model of the registers, built from the requirements
   logic [13:0] e_vl, e_vr;
   logic [9:0]  e_dac, e_pll;

   function automatic void model_reset();
      e_vl = 14'h3FFF; e_vr = 14'h3FFF; e_dac = '0; e_pll = '0;
   endfunction

   function automatic void model_write(input logic [15:0] w);
      case (w[1:0])
         2'b00: e_vl = w[15:2];
         2'b10: e_vr = w[15:2];
         2'b01: e_dac = {(w[11:10] == 2'b11) ? e_dac[9:8] : w[11:10], w[9:2]};
         default: e_pll = {w[11:8], (w[7:6] == 2'b01) ? e_pll[5:4] : w[7:6], w[5:2]};
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R5 vol_left"},  32'(vol_left),  32'(e_vl));
      chk({tag, " R4 vol_right"}, 32'(vol_right), 32'(e_vr));
      chk({tag, " R6 R7 dac"}, 32'({dac_interp, dac_width, dac_phase_inv, dac_soft_mute,
                                     dac_format, dac_deemph}), 32'(e_dac));
      chk({tag, " R8 R9 pll"}, 32'({pll2_off, pll1_off, xtal_off, ref_half, pll_rate,
                                     aclk_x384, aclk_dbl, dspclk_rate, mclk_is_in}), 32'(e_pll));
   endtask

   task automatic send(input logic [15:0] w, input int nbits);
      @(negedge clk) ser_lat = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         ser_dat = (i < 16) ? w[15-i] : 1'b0;
         ser_clk = 1'b0;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      ser_lat = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (5) @(negedge clk);
      chk("R1 vol_left in reset", 32'(vol_left), 32'h3FFF);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_all("R1 after reset");

      // Table walk: R2 ordering, R4 selection, R5..R9 fields
      for (int k = 0; k < N_VEC; k++) begin
         send(VEC[k], 16);
         model_write(VEC[k]);
         check_all($sformatf("R2 vec%0d", k));
      end

      // R3: short frame discarded
      send(16'h5551, 15);
      check_all("R3 short");
      // R3: long frame discarded
      send(16'h5550, 17);
      check_all("R3 long");

      // R10: clock edges while latch high are not counted
      for (int j = 0; j < 5; j++) begin
         @(negedge clk) ser_dat = 1'b1; ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      send(16'h2468, 16);
      model_write(16'h2468);
      check_all("R10 after idle clocks");

      // R7 and R9 again from a different prior value
      send(16'h0005, 16); model_write(16'h0005);
      send(16'h0C01, 16); model_write(16'h0C01);
      chk("R7 interp held", 32'(dac_interp), 32'h0);
      send(16'h008B, 16); model_write(16'h008B);
      send(16'h0043, 16); model_write(16'h0043);
      chk("R9 rate held", 32'(pll_rate), 32'h2);
      check_all("R7 R9");

      // R1: reset in mid operation restores defaults
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R1 mid reset");

      finish_run();
   end
endmodule